// File: doc/BRIEF.md
# Four-Beat Burst Offset Sequencer

This block produces the low-order address offset for a four-beat memory burst. When a new access starts, it captures a base offset from the two least significant bits of the external address. Each later advance then moves it to the next beat. The other address bits, the storage array and the bus control logic are handled elsewhere.

The beat order is either interleaved or linear. The interleaved order takes the base XOR the beat number. The linear order takes the base plus the beat number, wrapping modulo four. A strap input picks the order, and the block captures it only while reset is held. The advance strobe is active low. While it is inactive the burst is suspended and the offset holds. A fresh load replaces the base at any point, even in the middle of a burst.

Top module: `burst_offset_seq`

## Requirements
- R1: While `rst_n` is low at a rising edge, the offset becomes 0 after that edge.
- R2: A rising edge with `load` high makes `offset` equal to the `base` sampled at that edge. This also applies in the middle of a burst, and the beat number restarts at 0.
- R3: If `mode` was 0 at the last reset edge (linear order), each advance edge sets `offset` to the previous offset plus 1, modulo 4. A base of 1 gives 1, 2, 3, 0.
- R4: If `mode` was 1 at the last reset edge (interleaved order), after k advances since the load the offset equals base XOR (k mod 4). A base of 0 gives 0, 1, 2, 3.
- R5: After four advances the offset is back at the loaded base, and the sequence repeats without stopping.
- R6: An edge with `load` low and `adv_n` high leaves `offset` unchanged (suspend).
- R7: When `load` and an advance (`adv_n` low) arrive at the same edge, the load wins: the offset equals the new base, not base plus one beat.
- R8: Changes on `mode` while `rst_n` is high have no effect on the order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low; `mode` is captured while it is low |
| load | input | 1 | Starts a new burst from `base` |
| base | input | 2 | Starting offset, taken from the low external address bits |
| adv_n | input | 1 | Advance strobe, active low |
| mode | input | 1 | Order strap: 1 interleaved, 0 linear |
| offset | output | 2 | Current burst offset |

## Verification
The hardest case to reach from the ports is a `mode` change in the middle of a burst. Only sequences that run after that change can show whether the order was latched at reset. The bench therefore resets with one strap value and flips the strap immediately afterwards. It then sweeps every base through bursts that mix advances, suspends, wraps, mid-burst reloads and load-with-advance edges, and compares each beat against the order chosen at reset. This is done once for each strap value.

// File: rtl/burst_offset_seq.sv
module burst_offset_seq #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] base,
  input  logic             adv_n,
  input  logic             mode,
  output logic [CNT_W-1:0] offset
);
  logic [CNT_W-1:0] base_q;
  logic [CNT_W-1:0] beat_q;
  logic             ilv_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      beat_q <= '0;
      ilv_q  <= mode;
    end else if (load) begin
      base_q <= base;
      beat_q <= '0;
    end else if (!adv_n) begin
      beat_q <= beat_q + 1'b1;
    end
  end

  assign offset = ilv_q ? (base_q ^ beat_q) : (base_q + beat_q);
endmodule

module burst_offset_chk #(
  parameter int CNT_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             load,
  input logic [CNT_W-1:0] base,
  input logic             adv_n,
  input logic             ilv_q,
  input logic [CNT_W-1:0] offset
);
  p_reset_r1: assert property (@(posedge clk) !rst_n |=> offset == '0);
  p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> offset == $past(base));
  p_linear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ilv_q && !load && !adv_n) |=> offset == CNT_W'($past(offset) + 1'b1));
  p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !adv_n) |=> offset != $past(offset));
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && adv_n) |=> $stable(offset));
  p_mode_fixed_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> $stable(ilv_q));
endmodule

bind burst_offset_seq burst_offset_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .load(load), .base(base),
  .adv_n(adv_n), .ilv_q(ilv_q), .offset(offset)
);

// File: tb/tb_burst_offset_seq.sv
module tb_burst_offset_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       load = 1'b0;
  logic [1:0] base = 2'd0;
  logic       adv_n = 1'b1;
  logic       mode = 1'b0;
  logic [1:0] offset;

  int total = 0;
  int bad = 0;
  int cur_mode = 0;
  int cur_base = 0;
  int beats = 0;

  always #5 clk = ~clk;

  burst_offset_seq dut (
    .clk(clk), .rst_n(rst_n), .load(load), .base(base),
    .adv_n(adv_n), .mode(mode), .offset(offset)
  );

  function automatic logic [1:0] model();
    if (cur_mode != 0) return 2'(cur_base ^ (beats % 4));
    return 2'((cur_base + beats) % 4);
  endfunction

  task automatic check(input string req, input logic [1:0] exp);
    total++;
    if (offset !== exp) begin
      bad++;
      $display("FAIL %s: offset=%0d expected=%0d (mode=%0d base=%0d beats=%0d)",
               req, offset, exp, cur_mode, cur_base, beats);
    end
  endtask

  task automatic step(input logic ld, input logic [1:0] b, input logic an);
    @(negedge clk);
    load = ld; base = b; adv_n = an;
    @(posedge clk);
    #1;
    if (ld) begin cur_base = b; beats = 0; end
    else if (!an) beats++;
  endtask

  initial begin
    #2_000_000;
    total++; bad++;
    $display("FAIL watchdog: run did not finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int m = 0; m < 2; m++) begin
      @(negedge clk);
      rst_n = 1'b0; mode = m[0]; load = 1'b0; adv_n = 1'b0; base = 2'd3;
      @(posedge clk); #1;
      @(posedge clk); #1;
      cur_mode = m; cur_base = 0; beats = 0;
      check("R1 reset offset", 2'd0);
      @(negedge clk);
      rst_n = 1'b1;
      mode = ~m[0];  // R8: strap flipped after reset must not matter
      for (int b = 0; b < 4; b++) begin
        step(1'b1, 2'(b), 1'b0);
        check("R7 load beats advance", model());
        for (int k = 0; k < 9; k++) begin
          step(1'b0, 2'd0, 1'b0);
          check(m != 0 ? "R4 interleaved beat" : "R3 linear beat", model());
          if (beats == 4) check("R5 wrap to base", 2'(b));
          if (k == 2 || k == 5) begin
            step(1'b0, 2'd0, 1'b1);
            check("R6 hold on suspend", model());
            step(1'b0, 2'd0, 1'b1);
            check("R6 hold on suspend", model());
          end
        end
        step(1'b0, 2'd0, 1'b0);
        step(1'b1, 2'(3 - b), 1'b1);
        check("R2 reload mid-burst", 2'(3 - b));
        step(1'b0, 2'd0, 1'b0);
        check("R8 order fixed at reset", model());
        step(1'b0, 2'd0, 1'b0);
        check("R8 order fixed at reset", model());
      end
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule